// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between four external interrupt request pins and the priority encoder of a processor interrupt controller. Each pin is brought into the clock domain through a synchronizer. It is then qualified according to a per-line sense type: active-high level, active-low level, rising edge or falling edge. The qualified result is presented as one request bit per line.

A single 32-bit control word holds the configuration and is written and read over a minimal register bus. The word holds a 2-bit sense code and an enable bit for each line, a master enable that gates all four lines, and a bit that tells the interrupt controller whether the critical request is routed normally. Edge events are held in a sticky latch until software writes a one to that line's clear bit. The clear bits share the control word but are not stored.

Top module: `extirq_conditioner`

## Requirements
- R1: After synchronous reset the control word reads as zero, every request output is low and the routing output is low.
- R2: The control word stores, for line n (0..3), its sense code at bits [23-2n:22-2n] and its enable at bit 11-n. The master enable is at bit 12 and the critical-routing bit is at bit 0. Every other bit, including the clear field [27:24], reads back as zero.
- R3: Sense code 0 selects active-high level, 1 rising edge, 2 falling edge and 3 active-low level.
- R4: In a level mode the request of an enabled line follows the pin two clock edges after the pin changes, and drops again when the pin goes inactive, with nothing latched.
- R5: In an edge mode a matching pin transition sets a sticky latch, and the request is visible three clock edges after the pin changes. The latch stays set after the pin returns. An edge of the opposite polarity sets nothing.
- R6: A register write with bit 27-n set clears the latch of line n only. A write with that bit at zero leaves the latch unchanged.
- R7: When a matching edge is detected in the same cycle as a clear write for that line, the latch ends up set.
- R8: With its enable bit at zero a line's request stays low, and edges that arrive while it is disabled are not latched.
- R9: With the master enable at zero all four requests are low. Setting it releases lines that are enabled and active.
- R10: The critical-routing output equals the stored bit 0.
- R11: Switching a line to a level mode discards its latched edge, so switching back to an edge mode does not raise a stale request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data, including clear bits |
| reg_rdata | output | 32 | Stored control word |
| ext_pin | input | 4 | Asynchronous external request pins, bit n is line n |
| irq_req | output | 4 | Qualified requests to the priority encoder |
| crit_route_normal | output | 1 | Critical request handled normally |

## Verification
Two functions can fall in the same cycle: the setting of an edge latch and a software clear write to that same line. The bench raises the pin on one line and then asserts the write strobe, carrying that line's clear bit, exactly on the clock edge where the synchronized transition is first seen. That clock edge is the third one after the pin change. The request must remain high after this write, and only a later clear with no edge pending may drop it.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int NUM_LINES    = 4;
    localparam int REG_W        = 32;
    localparam int SENSE_W      = 2;
    localparam int SENSE_TOP_LSB = 22;   // line 0 sense LSB; later lines step down
    localparam int ENABLE_MSB   = 11;    // line 0 enable; later lines step down
    localparam int CLEAR_MSB    = 27;    // line 0 clear; later lines step down
    localparam int MASTER_BIT   = 12;
    localparam int ROUTE_BIT    = 0;
    localparam int SYNC_STAGES  = 2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LVL_HI = 2'd0,
        SENSE_RISE   = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_LVL_LO = 2'd3
    } sense_e;

    typedef struct packed {
        sense_e sense;
        logic   enable;
    } line_cfg_t;

    typedef struct packed {
        logic master;
        logic route_normal;
    } global_cfg_t;

    function automatic int sense_lsb(input int n);
        return SENSE_TOP_LSB - SENSE_W * n;
    endfunction

    function automatic int enable_pos(input int n);
        return ENABLE_MSB - n;
    endfunction

    function automatic int clear_pos(input int n);
        return CLEAR_MSB - n;
    endfunction

    function automatic logic sense_is_edge(input sense_e s);
        return (s == SENSE_RISE) || (s == SENSE_FALL);
    endfunction

    function automatic logic level_active(input sense_e s, input logic lvl);
        return (s == SENSE_LVL_LO) ? ~lvl : lvl;
    endfunction

    function automatic logic edge_hit(input sense_e s, input logic cur, input logic prev);
        logic hit;
        case (s)
            SENSE_RISE: hit = cur & ~prev;
            SENSE_FALL: hit = ~cur & prev;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic [REG_W-1:0] stored_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            m[sense_lsb(n) +: SENSE_W] = '1;
            m[enable_pos(n)]           = 1'b1;
        end
        m[MASTER_BIT] = 1'b1;
        m[ROUTE_BIT]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync
    import extirq_pkg::*;
#(
    parameter int LINES  = NUM_LINES,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pin_async,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] prev
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            logic              prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                    prev_q  <= 1'b0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], pin_async[g]};
                    prev_q  <= chain_q[STAGES-1];
                end
            end

            assign lvl[g]  = chain_q[STAGES-1];
            assign prev[g] = prev_q;
        end
    endgenerate

endmodule

// File: rtl/extirq_ctrl_reg.sv
module extirq_ctrl_reg
    import extirq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    output line_cfg_t [NUM_LINES-1:0]   line_cfg,
    output global_cfg_t                 glob_cfg,
    output logic [NUM_LINES-1:0]        clear_pulse
);

    localparam logic [REG_W-1:0] KEEP_MASK = stored_mask();

    logic [SENSE_W-1:0]   sense_q [NUM_LINES];
    logic [NUM_LINES-1:0] enable_q;
    logic                 master_q;
    logic                 route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                sense_q[n] <= '0;
            end
            enable_q <= '0;
            master_q <= 1'b0;
            route_q  <= 1'b0;
        end else if (we) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                sense_q[n]  <= wdata[sense_lsb(n) +: SENSE_W];
                enable_q[n] <= wdata[enable_pos(n)];
            end
            master_q <= wdata[MASTER_BIT];
            route_q  <= wdata[ROUTE_BIT];
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            line_cfg[n].sense  = sense_e'(sense_q[n]);
            line_cfg[n].enable = enable_q[n];
            clear_pulse[n]     = we & wdata[clear_pos(n)];
        end
        glob_cfg.master       = master_q;
        glob_cfg.route_normal = route_q;
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            rdata[sense_lsb(n) +: SENSE_W] = sense_q[n];
            rdata[enable_pos(n)]           = enable_q[n];
        end
        rdata[MASTER_BIT] = master_q;
        rdata[ROUTE_BIT]  = route_q;
    end

    logic unused_wbits;
    assign unused_wbits = ^(wdata & ~KEEP_MASK);

    // R2: a written master bit is the one read back on the next cycle
    p_master_write_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata[MASTER_BIT] == $past(wdata[MASTER_BIT])));

endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    input  logic      prev,
    input  line_cfg_t cfg,
    input  logic      master,
    input  logic      clr,
    output logic      req
);

    logic armed;
    logic edge_mode;
    logic hit;
    logic latch_q;

    assign armed     = master & cfg.enable;
    assign edge_mode = sense_is_edge(cfg.sense);
    assign hit       = edge_hit(cfg.sense, lvl, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
        end else if (!edge_mode) begin
            latch_q <= 1'b0;
        end else if (armed && hit) begin
            latch_q <= 1'b1;
        end else if (clr) begin
            latch_q <= 1'b0;
        end
    end

    assign req = armed & (edge_mode ? latch_q : level_active(cfg.sense, lvl));

    // R5: an armed matching edge leaves the latch set unless the mode left edge sensing
    p_edge_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && hit && edge_mode) |=> (latch_q || !sense_is_edge(cfg.sense)));

    // R6: a clear with no competing edge empties the latch
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && !(armed && hit)) |=> !latch_q);

    // R7: set wins over a same-cycle clear
    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && armed && hit && edge_mode) |=> (latch_q || !sense_is_edge(cfg.sense)));

    // R8: a disarmed line never newly latches
    p_disarmed_no_set_r8: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !$rose(latch_q));

    // R11: a line held in level mode carries no latched edge
    p_level_no_latch_r11: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && $past(!edge_mode)) |-> !latch_q);

endmodule

// File: rtl/extirq_conditioner.sv
module extirq_conditioner
    import extirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [3:0]  ext_pin,
    output logic [3:0]  irq_req,
    output logic        crit_route_normal
);

    line_cfg_t [NUM_LINES-1:0] line_cfg;
    global_cfg_t               glob_cfg;
    logic [NUM_LINES-1:0]      clear_pulse;
    logic [NUM_LINES-1:0]      sync_lvl;
    logic [NUM_LINES-1:0]      sync_prev;

    extirq_ctrl_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .line_cfg    (line_cfg),
        .glob_cfg    (glob_cfg),
        .clear_pulse (clear_pulse)
    );

    extirq_sync #(
        .LINES  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_pin),
        .lvl       (sync_lvl),
        .prev      (sync_prev)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_cond
            extirq_line u_line (
                .clk    (clk),
                .rst    (rst),
                .lvl    (sync_lvl[g]),
                .prev   (sync_prev[g]),
                .cfg    (line_cfg[g]),
                .master (glob_cfg.master),
                .clr    (clear_pulse[g]),
                .req    (irq_req[g])
            );
        end
    endgenerate

    assign crit_route_normal = glob_cfg.route_normal;

    // R9: master enable off means no request leaves the block
    p_master_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !glob_cfg.master |-> (irq_req == '0));

endmodule

// File: tb/extirq_conditioner_tb_top.sv
module extirq_conditioner_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ext_pin = '0;
    logic [3:0]  irq_req;
    logic        crit_route_normal;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    extirq_conditioner dut_i (
        .clk               (clk),
        .rst               (rst),
        .reg_we            (reg_we),
        .reg_wdata         (reg_wdata),
        .reg_rdata         (reg_rdata),
        .ext_pin           (ext_pin),
        .irq_req           (irq_req),
        .crit_route_normal (crit_route_normal)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops expected request vectors as they come due
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t it;
            it = exp_q.pop_front();
            chk(irq_req === it.val, it.tag, {28'd0, irq_req}, {28'd0, it.val});
        end
    end

    task automatic expect_at(input int dly, input logic [3:0] v, input string tag);
        exp_t it;
        it.due = cyc + dly;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic chk_req(input logic [3:0] v, input string tag);
        chk(irq_req === v, tag, {28'd0, irq_req}, {28'd0, v});
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        ext_pin[idx] = v;
    endtask

    function automatic logic [31:0] mk(input logic [1:0] s0, input logic [1:0] s1,
                                       input logic [1:0] s2, input logic [1:0] s3,
                                       input logic [3:0] en, input logic m, input logic r);
        logic [31:0] w;
        w = '0;
        w[23:22] = s0;
        w[21:20] = s1;
        w[19:18] = s2;
        w[17:16] = s3;
        w[11] = en[0];
        w[10] = en[1];
        w[9]  = en[2];
        w[8]  = en[3];
        w[12] = m;
        w[0]  = r;
        return w;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(reg_rdata === 32'h0, "R1 rdata", reg_rdata, 32'h0);
        chk_req(4'b0000, "R1 req");
        chk(crit_route_normal === 1'b0, "R1 route", {31'd0, crit_route_normal}, 32'h0);

        // R2: field placement and read-as-zero bits
        wr(32'hFFFF_FFFF);
        chk(reg_rdata === 32'h00FF_1F01, "R2 all-ones", reg_rdata, 32'h00FF_1F01);
        chk_req(4'b1111, "R3 level-low all lines pins low");
        w = mk(2'd1, 2'd2, 2'd3, 2'd0, 4'b0101, 1'b1, 1'b1);
        wr(w);
        chk(reg_rdata === w, "R2 pattern", reg_rdata, w);
        wr(32'h0);

        // R4/R3: level high on line 0
        wr(mk(0, 0, 0, 0, 4'b0001, 1, 0));
        chk_req(4'b0000, "R4 idle");
        set_pin(0, 1'b1);
        expect_at(1, 4'b0000, "R4 one edge after pin");
        expect_at(2, 4'b0001, "R4 follows pin high");
        step(3);
        set_pin(0, 1'b0);
        expect_at(1, 4'b0001, "R4 still high one edge after drop");
        expect_at(2, 4'b0000, "R4 follows pin low");
        step(3);
        wr(32'h0);

        // R3: level low on line 3
        wr(mk(0, 0, 0, 3, 4'b1000, 1, 0));
        chk_req(4'b1000, "R3 level low active");
        set_pin(3, 1'b1);
        expect_at(2, 4'b0000, "R3 level low released");
        step(3);
        set_pin(3, 1'b0);
        expect_at(2, 4'b1000, "R3 level low again");
        step(3);
        wr(32'h0);

        // R5/R6: rising on line 1
        w = mk(0, 1, 0, 0, 4'b0010, 1, 0);
        wr(w);
        set_pin(1, 1'b1);
        expect_at(2, 4'b0000, "R5 not before third edge");
        expect_at(3, 4'b0010, "R5 rising latched");
        step(4);
        set_pin(1, 1'b0);
        expect_at(3, 4'b0010, "R5 sticky after pin falls");
        step(4);
        wr(w);
        chk_req(4'b0010, "R6 zero clear bit keeps latch");
        wr(w | (32'h1 << 26));
        chk_req(4'b0000, "R6 clear line 1");

        // R6: clear one of two latched lines
        w = mk(0, 1, 1, 0, 4'b0110, 1, 0);
        wr(w);
        @(negedge clk);
        ext_pin[1] = 1'b1;
        ext_pin[2] = 1'b1;
        expect_at(3, 4'b0110, "R6 two lines latched");
        step(4);
        wr(w | (32'h1 << 25));
        chk_req(4'b0010, "R6 clear line 2 only");
        wr(32'h0);
        @(negedge clk);
        ext_pin = 4'b0000;
        step(3);

        // R5: falling on line 2 ignores rising
        wr(mk(0, 0, 2, 0, 4'b0100, 1, 0));
        set_pin(2, 1'b1);
        expect_at(3, 4'b0000, "R5 rise ignored in falling mode");
        step(4);
        set_pin(2, 1'b0);
        expect_at(2, 4'b0000, "R5 falling not yet");
        expect_at(3, 4'b0100, "R5 falling latched");
        step(4);
        wr(32'h0);

        // R7: edge and clear in the same cycle
        w = mk(1, 0, 0, 0, 4'b0001, 1, 0);
        wr(w);
        @(negedge clk);
        ext_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = w | (32'h1 << 27);
        @(negedge clk);
        reg_we    = 1'b0;
        reg_wdata = '0;
        chk_req(4'b0001, "R7 set beats clear");
        wr(w | (32'h1 << 27));
        chk_req(4'b0000, "R7 later clear works");
        set_pin(0, 1'b0);
        step(3);
        wr(32'h0);

        // R8: disabled line does not latch
        wr(mk(1, 0, 0, 0, 4'b0000, 1, 0));
        set_pin(0, 1'b1);
        expect_at(3, 4'b0000, "R8 disabled no request");
        step(4);
        wr(mk(1, 0, 0, 0, 4'b0001, 1, 0));
        chk_req(4'b0000, "R8 no stale edge after enable");
        set_pin(0, 1'b0);
        step(3);
        wr(32'h0);

        // R9: master enable
        wr(mk(0, 0, 0, 0, 4'b0001, 0, 0));
        set_pin(0, 1'b1);
        expect_at(2, 4'b0000, "R9 master off blocks");
        step(3);
        wr(mk(0, 0, 0, 0, 4'b0001, 1, 0));
        chk_req(4'b0001, "R9 master on releases");
        wr(mk(0, 0, 0, 0, 4'b0001, 0, 0));
        chk_req(4'b0000, "R9 master off again");
        set_pin(0, 1'b0);
        step(3);
        wr(32'h0);

        // R11: mode switch discards latch
        wr(mk(0, 1, 0, 0, 4'b0010, 1, 0));
        set_pin(1, 1'b1);
        expect_at(3, 4'b0010, "R11 latched before switch");
        step(4);
        set_pin(1, 1'b0);
        step(3);
        wr(mk(0, 0, 0, 0, 4'b0010, 1, 0));
        chk_req(4'b0000, "R11 level mode pin low");
        step(2);
        wr(mk(0, 1, 0, 0, 4'b0010, 1, 0));
        chk_req(4'b0000, "R11 no stale latch");
        wr(32'h0);

        // R10: routing bit
        wr(32'h0000_0001);
        chk(crit_route_normal === 1'b1, "R10 route set", {31'd0, crit_route_normal}, 32'h1);
        chk(reg_rdata === 32'h1, "R10 rdata", reg_rdata, 32'h1);
        wr(32'h0);
        chk(crit_route_normal === 1'b0, "R10 route clear", {31'd0, crit_route_normal}, 32'h0);

        step(5);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule